// File: doc/BRIEF.md
# Registered sum-of-products logic array

This block is a small field-configurable logic array in the fixed-OR style. A configurable AND plane forms product terms over the primary inputs and over the fed-back cell outputs. Each output cell ORs a private group of product terms, and that grouping cannot be changed. The cell then passes the result into a storage element. Per cell, the storage element is configured to act as a D, T, JK or clocked SR flip-flop.

Every registered output is routed back into the AND plane as an additional literal. This makes it possible to configure counters, sequence detectors and other small state machines entirely through configuration bits. The configuration is a pair of static vectors: the AND-plane fuse map and a two-bit flip-flop kind for each cell. Programming electronics and output tri-state drivers are outside the block.

Top module: `pal_array`

## Requirements
- R1: Every product term has two configuration bits for each literal. Bit 2*l set means the term requires literal l to be 1, and bit 2*l+1 set means it requires literal l to be 0. With neither bit set, the literal is ignored. A term is the AND of all the literals it requires.
- R2: A product term with no configuration bit set evaluates to 0, so that an unused term cannot disturb its cell. A term that requires one literal in both forms also evaluates to 0.
- R3: Cell c owns terms t = 0..N_TERM-1. The configuration of term t of cell c starts at bit ((c*N_TERM + t)*(N_IN+N_CELL))*2 of `and_fuse`. A term affects only the cell that owns it.
- R4: Literals 0..N_IN-1 are `din`, and literal N_IN+c is the registered output of cell c. A cell can therefore react to its own state or to another cell's state one clock later.
- R5: The flip-flop kind is `ff_mode[2c+1:2c]`: 00 = D, 01 = T, 10 = JK, 11 = SR. In D kind, the register loads the OR of all the cell's terms.
- R6: In T kind, the register inverts when the OR of all the cell's terms is 1, and holds otherwise.
- R7: In JK kind, J is the OR of the lower half of the terms (t < N_TERM/2) and K is the OR of the upper half. J=1,K=0 sets the register, J=0,K=1 clears it, both 0 holds it, and both 1 inverts it.
- R8: In SR kind, S is the OR of the lower half and R is the OR of the upper half. S alone sets the register, R alone clears it, and S and R both 0 or both 1 hold it.
- R9: `rst` is synchronous and clears every cell register to 0 at the next rising edge. `dout` is the register itself, so a change of inputs shows at `dout` only after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst | input | 1 | Synchronous clear of all cell registers, active high |
| din | input | N_IN | Primary inputs to the AND plane |
| and_fuse | input | N_CELL*N_TERM*2*(N_IN+N_CELL) | AND-plane configuration, two bits per literal per term |
| ff_mode | input | 2*N_CELL | Flip-flop kind per cell, two bits each |
| dout | output | N_CELL | Registered cell outputs, also fed back as literals |

## Verification
The bench goes after several corner cases. Empty terms and contradictory terms are covered: a design that treated an unconfigured term as true would drive every idle cell to 1. A configuration that places a term in a neighbouring cell's slot is covered, which exposes any mistake in the fuse offset. A cell that inverts its own fed-back output is used as well: a swapped or misaligned feedback literal would stop it from toggling. The JK and SR kinds are driven through all four control combinations. Swapped halves, or an SR design that toggles or sets when both S and R are high, therefore show up as wrong outputs. Random configurations with random reset pulses are then compared every cycle with a model in the bench.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Storage behaviour of one output cell
    typedef enum logic [1:0] {
        FF_D  = 2'b00,
        FF_T  = 2'b01,
        FF_JK = 2'b10,
        FF_SR = 2'b11
    } ff_kind_e;

endpackage

// File: rtl/pal_term.sv
module pal_term #(
    parameter int NLIT = 8
) (
    input  logic [NLIT-1:0]   lits,
    input  logic [2*NLIT-1:0] fuse,
    output logic              hit
);

    logic used;
    logic match;

    always_comb begin
        used  = 1'b0;
        match = 1'b1;
        for (int l = 0; l < NLIT; l++) begin
            used = used | fuse[2*l] | fuse[2*l+1];
            if (fuse[2*l] && !lits[l])
                match = 1'b0;
            if (fuse[2*l+1] && lits[l])
                match = 1'b0;
        end
        // an unconfigured term must not fire (R2)
        hit = used & match;
    end

endmodule

// File: rtl/pal_cell.sv
module pal_cell
    import pal_pkg::*;
#(
    parameter int NLIT  = 8,
    parameter int NTERM = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NLIT-1:0]         lits,
    input  logic [NTERM*2*NLIT-1:0] fuse,
    input  logic [1:0]              mode,
    output logic                    q,
    output logic                    sum,
    output logic                    half_lo,
    output logic                    half_hi
);

    localparam int HALF = NTERM / 2;
    localparam int TW   = 2 * NLIT;

    logic [NTERM-1:0] hits;
    logic             state_q;
    logic             state_d;
    ff_kind_e         kind;

    for (genvar t = 0; t < NTERM; t++) begin : g_term
        pal_term #(.NLIT(NLIT)) u_term (
            .lits (lits),
            .fuse (fuse[t*TW +: TW]),
            .hit  (hits[t])
        );
    end

    assign half_lo = |hits[HALF-1:0];
    assign half_hi = |hits[NTERM-1:HALF];
    assign sum     = half_lo | half_hi;
    assign kind    = ff_kind_e'(mode);

    // next-state selection per storage kind
    always_comb begin
        state_d = state_q;
        unique case (kind)
            FF_D:  state_d = sum;
            FF_T:  state_d = state_q ^ sum;
            FF_JK: begin
                unique case ({half_lo, half_hi})
                    2'b10:   state_d = 1'b1;
                    2'b01:   state_d = 1'b0;
                    2'b11:   state_d = ~state_q;
                    default: state_d = state_q;
                endcase
            end
            FF_SR: begin
                unique case ({half_lo, half_hi})
                    2'b10:   state_d = 1'b1;
                    2'b01:   state_d = 1'b0;
                    default: state_d = state_q;
                endcase
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= 1'b0;
        else
            state_q <= state_d;
    end

    assign q = state_q;

endmodule

// File: rtl/pal_array.sv
module pal_array #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 4,
    parameter int N_CELL = 4
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [N_IN-1:0]                          din,
    input  logic [N_CELL*N_TERM*2*(N_IN+N_CELL)-1:0] and_fuse,
    input  logic [2*N_CELL-1:0]                      ff_mode,
    output logic [N_CELL-1:0]                        dout
);

    localparam int NLIT    = N_IN + N_CELL;
    localparam int CELL_FW = N_TERM * 2 * NLIT;

    logic [NLIT-1:0]   lits;
    logic [N_CELL-1:0] q_vec;
    logic [N_CELL-1:0] sum_vec;
    logic [N_CELL-1:0] lo_vec;
    logic [N_CELL-1:0] hi_vec;

    // primary inputs first, then the fed-back cell registers
    assign lits = {q_vec, din};

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        pal_cell #(.NLIT(NLIT), .NTERM(N_TERM)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .lits    (lits),
            .fuse    (and_fuse[c*CELL_FW +: CELL_FW]),
            .mode    (ff_mode[2*c +: 2]),
            .q       (q_vec[c]),
            .sum     (sum_vec[c]),
            .half_lo (lo_vec[c]),
            .half_hi (hi_vec[c])
        );
    end

    assign dout = q_vec;

endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
    parameter int N_CELL = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [2*N_CELL-1:0] ff_mode,
    input logic [N_CELL-1:0] dout,
    input logic [N_CELL-1:0] sum_vec,
    input logic [N_CELL-1:0] lo_vec,
    input logic [N_CELL-1:0] hi_vec
);

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (dout == '0));

    for (genvar c = 0; c < N_CELL; c++) begin : g_chk
        // R5
        d_load_chk: assert property (@(posedge clk) disable iff (rst)
            (ff_mode[2*c +: 2] == 2'b00) |=> (dout[c] == $past(sum_vec[c])));
        // R6
        t_toggle_chk: assert property (@(posedge clk) disable iff (rst)
            (ff_mode[2*c +: 2] == 2'b01) |=> (dout[c] == ($past(dout[c]) ^ $past(sum_vec[c]))));
        // R7
        jk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
            (ff_mode[2*c +: 2] == 2'b10 && lo_vec[c] && hi_vec[c]) |=> (dout[c] != $past(dout[c])));
        // R8
        sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (ff_mode[2*c +: 2] == 2'b11 && lo_vec[c] && hi_vec[c]) |=> $stable(dout[c]));
    end

endmodule

bind pal_array pal_array_chk #(.N_CELL(N_CELL)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ff_mode (ff_mode),
    .dout    (dout),
    .sum_vec (sum_vec),
    .lo_vec  (lo_vec),
    .hi_vec  (hi_vec)
);

// File: tb/pal_array_tb.sv
`timescale 1ns/1ps
module pal_array_tb;

    localparam int N_IN   = 4;
    localparam int N_TERM = 4;
    localparam int N_CELL = 4;
    localparam int NLIT   = N_IN + N_CELL;
    localparam int FW     = N_CELL * N_TERM * 2 * NLIT;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_IN-1:0]   din = '0;
    logic [FW-1:0]     fuse = '0;
    logic [2*N_CELL-1:0] mode = '0;
    logic [N_CELL-1:0] dout;
    logic [N_CELL-1:0] exp_q = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pal_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_CELL(N_CELL)) u_dut (
        .clk (clk), .rst (rst), .din (din),
        .and_fuse (fuse), .ff_mode (mode), .dout (dout)
    );

    // R1 R3: bit 2*l = require 1, bit 2*l+1 = require 0
    task automatic set_lit(int c, int t, int l, bit neg);
        fuse[((c*N_TERM + t)*NLIT + l)*2 + (neg ? 1 : 0)] = 1'b1;
    endtask

    function automatic logic term_model(int c, int t, logic [NLIT-1:0] v);
        logic any = 1'b0;
        logic ok  = 1'b1;
        for (int l = 0; l < NLIT; l++) begin
            int b = ((c*N_TERM + t)*NLIT + l)*2;
            if (fuse[b] || fuse[b+1]) any = 1'b1;
            if (fuse[b] && v[l] != 1'b1) ok = 1'b0;
            if (fuse[b+1] && v[l] != 1'b0) ok = 1'b0;
        end
        return any && ok;
    endfunction

    function automatic logic cell_model(int c);
        logic [NLIT-1:0] v = {exp_q, din};
        logic a = 1'b0;
        logic b = 1'b0;
        logic q = exp_q[c];
        for (int t = 0; t < N_TERM; t++) begin
            if (t < N_TERM/2) a = a | term_model(c, t, v);
            else              b = b | term_model(c, t, v);
        end
        case (mode[2*c +: 2])
            2'b00: return a | b;
            2'b01: return q ^ (a | b);
            2'b10: return (a && !b) ? 1'b1 : (!a && b) ? 1'b0 : (a && b) ? !q : q;
            default: return (a && !b) ? 1'b1 : (!a && b) ? 1'b0 : q;
        endcase
    endfunction

    task automatic tick(string tag);
        logic [N_CELL-1:0] nxt;
        bit was_rst = rst;
        for (int c = 0; c < N_CELL; c++) nxt[c] = rst ? 1'b0 : cell_model(c);
        @(posedge clk);
        @(negedge clk);
        exp_q = nxt;
        for (int c = 0; c < N_CELL; c++) begin
            string t = tag;
            if (t == "") begin
                if (was_rst) t = "R9";
                else case (mode[2*c +: 2])
                    2'b00: t = "R5";
                    2'b01: t = "R6";
                    2'b10: t = "R7";
                    default: t = "R8";
                endcase
            end
            checks++;
            if (dout[c] !== exp_q[c]) begin
                errors++;
                $display("FAIL %s cell %0d: got %0b expected %0b", t, c, dout[c], exp_q[c]);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick("R9");
        tick("R9");
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        @(negedge clk);
        do_reset();

        // R1: true form, complement form, two-literal AND, all D kind
        fuse = '0; mode = '0;
        set_lit(0, 0, 0, 1'b0);
        set_lit(1, 0, 0, 1'b1);
        set_lit(2, 0, 0, 1'b0); set_lit(2, 0, 1, 1'b0);
        for (int p = 0; p < 8; p++) begin din = 4'(p % 4); tick("R1"); end

        // R2: empty terms and a contradictory term stay 0
        fuse = '0;
        set_lit(3, 1, 2, 1'b0); set_lit(3, 1, 2, 1'b1);
        for (int p = 0; p < 6; p++) begin din = 4'(p * 5); tick("R2"); end

        // R3: a term in cell 1's upper slot moves only cell 1
        fuse = '0;
        set_lit(1, 3, 3, 1'b0);
        for (int p = 0; p < 6; p++) begin din = (p % 2) ? 4'h8 : 4'h7; tick("R3"); end

        // R4: cell 0 inverts its own feedback, cell 1 copies cell 0
        do_reset();
        fuse = '0;
        set_lit(0, 0, N_IN + 0, 1'b1);
        set_lit(1, 0, N_IN + 0, 1'b0);
        for (int p = 0; p < 6; p++) tick("R4");

        // R6 T, R7 JK, R8 SR: lower half term 0 = din0, upper term 2 = din1
        do_reset();
        fuse = '0;
        mode = {2'b00, 2'b01, 2'b11, 2'b10};
        for (int c = 0; c < 3; c++) begin
            set_lit(c, 0, 0, 1'b0);
            set_lit(c, 2, 1, 1'b0);
        end
        begin
            logic [1:0] seq [8] = '{2'b01, 2'b00, 2'b11, 2'b11, 2'b10, 2'b11, 2'b01, 2'b00};
            for (int p = 0; p < 8; p++) begin din = {2'b00, seq[p]}; tick(""); end
        end

        // random configurations and stimulus
        for (int cfg = 0; cfg < 20; cfg++) begin
            for (int b = 0; b < FW/2; b++) begin
                int r = $urandom_range(0, 9);
                fuse[2*b]   = (r == 0);
                fuse[2*b+1] = (r == 1);
            end
            mode = (2*N_CELL)'($urandom);
            for (int n = 0; n < 300; n++) begin
                din = N_IN'($urandom);
                rst = ($urandom_range(0, 49) == 0);
                tick("");
            end
            rst = 1'b0;
        end

        finish_run();
    end

endmodule